// File: doc/BRIEF.md
# Paged Memory Load and Commit Controller

This block is the back end of a serial programming path. It takes instructions that have already been decoded and holds two staging buffers. One buffer collects a page of 16-bit program words, one byte at a time. The other collects a small page of data-store bytes. A commit instruction copies a staged page into an internal storage array that stands in for the nonvolatile cells. The data store can also be written one byte at a time. The block models the time a write takes with a down-counter, and it exposes the busy state both as a pin and through a poll instruction.

Instructions arrive on a valid/ready command channel. Read and poll instructions produce a byte on a valid/ready response channel. Back-pressure works as follows. The response register holds one byte. While that byte is waiting and `rsp_ready` is low, `cmd_ready` is low and no instruction is taken. A command is accepted on a clock edge where both `cmd_valid` and `cmd_ready` are high. Its response appears one cycle later and stays stable until it is taken. The `busy` and `order_err` pins are plain status outputs.

Opcode values on `cmd_op`:
- 1: program low byte load
- 2: program high byte load
- 3: program page commit
- 4: data byte load into the page buffer
- 5: data page commit
- 6: single data byte write
- 7: program word low-byte read
- 8: program word high-byte read
- 9: data byte read
- 10: busy poll
- 11: erase all

Any other value is accepted and does nothing.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `order_err` are 0, `cmd_ready` is 1, and every program word reads 0xFFFF and every data byte reads 0xFF.
- R2: Opcode 1 stores `cmd_data` as the low byte and opcode 2 as the high byte of buffer word `cmd_addr[4:0]`. Opcode 3 writes all 32 buffer words to program page `cmd_addr[7:5]`, word `w` going to address `{cmd_addr[7:5], w}`. Words never loaded are written as 0xFFFF.
- R3: A high-byte load for a word whose low byte has not been loaded since the last program commit is not stored, and `order_err` is 1 for exactly the cycle after it is accepted.
- R4: After a program commit the buffer holds 0xFFFF in every word and no low byte counts as loaded. A commit with no loads in between therefore writes 0xFFFF to every word of the page.
- R5: Opcode 4 stores `cmd_data` in data buffer byte `cmd_addr[1:0]` and marks it as loaded. Opcode 5 writes only the marked bytes to data addresses `{cmd_addr[5:2], i}`, leaves the other bytes of that page unchanged, and clears every mark.
- R6: Opcode 6 replaces data byte `cmd_addr[5:0]` with `cmd_data`.
- R7: Opcode 11 sets every program word to 0xFFFF and every data byte to 0xFF.
- R8: An accepted program commit or erase holds `busy` at 1 for exactly FLASH_CYCLES cycles. An accepted data-page commit or single-byte write holds it for exactly EE_CYCLES cycles. In both cases `busy` rises in the cycle after acceptance.
- R9: Opcodes 3, 5, 6 and 11 accepted while `busy` is 1 change no stored contents, do not clear either buffer, and do not restart the counter.
- R10: An accepted read (opcodes 7, 8, 9) returns the addressed byte on `rsp_data` with `rsp_valid` in the next cycle. The response stays valid and stable, and `cmd_ready` stays 0, until `rsp_ready` is 1. Undefined opcodes produce no response and change nothing.
- R11: Opcode 10 returns 0x01 if `busy` was 1 when the command was accepted, and 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 4 | Opcode |
| cmd_addr | input | ADDR_W | Address operand |
| cmd_data | input | 8 | Data byte operand |
| rsp_valid | output | 1 | Response byte present |
| rsp_ready | input | 1 | Response byte taken |
| rsp_data | output | 8 | Response byte |
| busy | output | 1 | Write timer running |
| order_err | output | 1 | One-cycle pulse for a rejected high-byte load |

## Verification
The bench aims at four corner cases.

- High-byte loads with no prior low byte, including one right after a commit. A design that ignores the ordering rule would store the stray byte or fail to pulse the error.
- Partial data-page commits over bytes that were pre-written. A design without a loaded-byte mask would overwrite the untouched neighbours. A design that keeps the mask after a commit would rewrite them on the next empty commit.
- Write commands sent while the timer runs. A design that does not gate them would change stored contents or stretch the busy window.
- A held response under back-pressure. A design that drops or changes it would lose a read.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_LD_FLO   = 4'd1,
    OP_LD_FHI   = 4'd2,
    OP_WR_FPG   = 4'd3,
    OP_LD_EE    = 4'd4,
    OP_WR_EPG   = 4'd5,
    OP_WR_EBYTE = 4'd6,
    OP_RD_FLO   = 4'd7,
    OP_RD_FHI   = 4'd8,
    OP_RD_EE    = 4'd9,
    OP_POLL     = 4'd10,
    OP_ERASE    = 4'd11
  } op_e;
endpackage

// File: rtl/pmc_flash_buf.sv
module pmc_flash_buf #(
  parameter int IDX_W = 5,
  localparam int WORDS = 1 << IDX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_lo,
  input  logic                   ld_hi,
  input  logic                   clr,
  input  logic [IDX_W-1:0]       idx,
  input  logic [7:0]             byte_in,
  output logic [WORDS-1:0][15:0] words,
  output logic                   order_err
);
  logic [WORDS-1:0] lo_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words     <= '1;
      lo_seen   <= '0;
      order_err <= 1'b0;
    end else begin
      order_err <= 1'b0;
      if (clr) begin
        words   <= '1;
        lo_seen <= '0;
      end else if (ld_lo) begin
        words[idx][7:0] <= byte_in;
        lo_seen[idx]    <= 1'b1;
      end else if (ld_hi) begin
        if (lo_seen[idx]) words[idx][15:8] <= byte_in;
        else              order_err        <= 1'b1;
      end
    end
  end

  AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi && !clr && !ld_lo && !lo_seen[idx]) |=> order_err); // R3
endmodule

// File: rtl/pmc_ee_buf.sv
module pmc_ee_buf #(
  parameter int IDX_W = 2,
  localparam int BYTES = 1 << IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld,
  input  logic                  clr,
  input  logic [IDX_W-1:0]      idx,
  input  logic [7:0]            byte_in,
  output logic [BYTES-1:0][7:0] bytes,
  output logic [BYTES-1:0]      mask
);
  for (genvar b = 0; b < BYTES; b++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bytes[b] <= '1;
        mask[b]  <= 1'b0;
      end else if (clr) begin
        mask[b] <= 1'b0;
      end else if (ld && idx == IDX_W'(b)) begin
        bytes[b] <= byte_in;
        mask[b]  <= 1'b1;
      end
    end
  end

  AST_EE_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> mask[$past(idx)]); // R5
endmodule

// File: rtl/pmc_timer.sv
module pmc_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cycles,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= cycles;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R9
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import pmc_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int WORD_IDX_W   = 5,
  parameter int EE_IDX_W     = 2,
  parameter int EPAGE_W      = 4,
  parameter int CNT_W        = 16,
  parameter int FLASH_CYCLES = 20,
  parameter int EE_CYCLES    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic              busy,
  output logic              order_err
);
  localparam int FL_WORDS = 1 << ADDR_W;
  localparam int PG_WORDS = 1 << WORD_IDX_W;
  localparam int EE_AW    = EE_IDX_W + EPAGE_W;
  localparam int EE_BYTES = 1 << EE_AW;
  localparam int PG_BYTES = 1 << EE_IDX_W;

  logic [15:0] fl_mem [FL_WORDS];
  logic [7:0]  ee_mem [EE_BYTES];

  op_e  op;
  logic take, is_wr, wr_go, flash_like;
  logic [ADDR_W-WORD_IDX_W-1:0]   fpage;
  logic [EPAGE_W-1:0]             epage;
  logic [EE_AW-1:0]               eaddr;
  logic [PG_WORDS-1:0][15:0]      fbuf;
  logic [PG_BYTES-1:0][7:0]       ebuf;
  logic [PG_BYTES-1:0]            emask;

  assign op         = op_e'(cmd_op);
  assign cmd_ready  = !rsp_valid || rsp_ready;
  assign take       = cmd_valid && cmd_ready;
  assign is_wr      = take && (op == OP_WR_FPG || op == OP_WR_EPG ||
                               op == OP_WR_EBYTE || op == OP_ERASE);
  assign wr_go      = is_wr && !busy;
  assign flash_like = (op == OP_WR_FPG) || (op == OP_ERASE);
  assign fpage      = cmd_addr[ADDR_W-1:WORD_IDX_W];
  assign eaddr      = cmd_addr[EE_AW-1:0];
  assign epage      = eaddr[EE_AW-1:EE_IDX_W];

  pmc_flash_buf #(.IDX_W(WORD_IDX_W)) u_fbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_lo     (take && op == OP_LD_FLO),
    .ld_hi     (take && op == OP_LD_FHI),
    .clr       (wr_go && op == OP_WR_FPG),
    .idx       (cmd_addr[WORD_IDX_W-1:0]),
    .byte_in   (cmd_data),
    .words     (fbuf),
    .order_err (order_err)
  );

  pmc_ee_buf #(.IDX_W(EE_IDX_W)) u_ebuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (take && op == OP_LD_EE),
    .clr     (wr_go && op == OP_WR_EPG),
    .idx     (cmd_addr[EE_IDX_W-1:0]),
    .byte_in (cmd_data),
    .bytes   (ebuf),
    .mask    (emask)
  );

  pmc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (wr_go),
    .cycles (flash_like ? CNT_W'(FLASH_CYCLES) : CNT_W'(EE_CYCLES)),
    .busy   (busy)
  );

  // Storage arrays standing in for the nonvolatile cells
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FL_WORDS; i++) fl_mem[i] <= '1;
      for (int i = 0; i < EE_BYTES; i++) ee_mem[i] <= '1;
    end else if (wr_go) begin
      case (op)
        OP_WR_FPG:
          for (int w = 0; w < PG_WORDS; w++)
            fl_mem[{fpage, WORD_IDX_W'(w)}] <= fbuf[w];
        OP_WR_EPG:
          for (int b = 0; b < PG_BYTES; b++)
            if (emask[b]) ee_mem[{epage, EE_IDX_W'(b)}] <= ebuf[b];
        OP_WR_EBYTE:
          ee_mem[eaddr] <= cmd_data;
        OP_ERASE: begin
          for (int i = 0; i < FL_WORDS; i++) fl_mem[i] <= '1;
          for (int i = 0; i < EE_BYTES; i++) ee_mem[i] <= '1;
        end
        default: ;
      endcase
    end
  end

  // Single-entry response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take && (op == OP_RD_FLO || op == OP_RD_FHI ||
                          op == OP_RD_EE  || op == OP_POLL)) begin
      rsp_valid <= 1'b1;
      case (op)
        OP_RD_FLO: rsp_data <= fl_mem[cmd_addr][7:0];
        OP_RD_FHI: rsp_data <= fl_mem[cmd_addr][15:8];
        OP_RD_EE:  rsp_data <= ee_mem[eaddr];
        default:   rsp_data <= {7'd0, busy};
      endcase
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10
  AST_RSP_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(take)); // R10
endmodule

// File: tb/page_commit_ctrl_test.sv
`timescale 1ns/1ps
module page_commit_ctrl_test;
  localparam int FC = 20;
  localparam int EC = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [3:0] cmd_op = '0;
  logic [7:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       busy;
  logic       order_err;

  always #10 clk = ~clk;

  page_commit_ctrl #(.FLASH_CYCLES(FC), .EE_CYCLES(EC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .order_err(order_err)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] fl [256];
  logic [7:0]  ee [64];
  logic [15:0] mb [32];
  bit          mlo [32];
  logic [7:0]  eb [4];
  bit          em [4];
  int          busy_end = -1;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic clear_fbuf();
    for (int i = 0; i < 32; i++) begin mb[i] = 16'hFFFF; mlo[i] = 0; end
  endtask

  // Drives one command, updates the model, checks status at the next negedge
  task automatic send(input logic [3:0] op, input logic [7:0] a, input logic [7:0] d);
    int e;
    bit ign, exp_err, is_rd;
    logic [7:0] exp_rsp;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(posedge clk);
    e = cyc;
    ign = (e <= busy_end);
    exp_err = 0; is_rd = 0; exp_rsp = '0;
    case (op)
      4'd1: begin mb[a[4:0]][7:0] = d; mlo[a[4:0]] = 1; end
      4'd2: if (mlo[a[4:0]]) mb[a[4:0]][15:8] = d; else exp_err = 1;
      4'd3: if (!ign) begin
              for (int w = 0; w < 32; w++) fl[{a[7:5], w[4:0]}] = mb[w];
              clear_fbuf(); busy_end = e + FC;
            end
      4'd4: begin eb[a[1:0]] = d; em[a[1:0]] = 1; end
      4'd5: if (!ign) begin
              for (int b = 0; b < 4; b++) begin
                if (em[b]) ee[{a[5:2], b[1:0]}] = eb[b];
                em[b] = 0;
              end
              busy_end = e + EC;
            end
      4'd6: if (!ign) begin ee[a[5:0]] = d; busy_end = e + EC; end
      4'd7: begin is_rd = 1; exp_rsp = fl[a][7:0]; end
      4'd8: begin is_rd = 1; exp_rsp = fl[a][15:8]; end
      4'd9: begin is_rd = 1; exp_rsp = ee[a[5:0]]; end
      4'd10: begin is_rd = 1; exp_rsp = {7'd0, ign}; end
      4'd11: if (!ign) begin
               for (int i = 0; i < 256; i++) fl[i] = 16'hFFFF;
               for (int i = 0; i < 64; i++) ee[i] = 8'hFF;
               busy_end = e + FC;
             end
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R3 order_err", order_err, exp_err);
    chk("R8 busy", busy, (e < busy_end));
    chk("R10 rsp_valid", rsp_valid, is_rd);
    if (is_rd) chk((op == 4'd10) ? "R11 poll" : "R10 read data", rsp_data, exp_rsp);
  endtask

  task automatic idle();
    repeat (FC + 3) @(posedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_0123));
    for (int i = 0; i < 256; i++) fl[i] = 16'hFFFF;
    for (int i = 0; i < 64; i++) ee[i] = 8'hFF;
    for (int i = 0; i < 4; i++) begin eb[i] = 8'hFF; em[i] = 0; end
    clear_fbuf();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
    chk("R1 order_err", order_err, 0);
    send(4'd8, 8'h37, 0);
    send(4'd9, 8'h05, 0);

    // R2 program page load and commit
    send(4'd1, 8'h03, 8'hEF);
    send(4'd2, 8'h03, 8'hBE);
    send(4'd1, 8'h1F, 8'h12);
    send(4'd3, 8'hA0, 0);
    n = 1;
    while (busy) begin @(negedge clk); if (busy) n++; end
    chk("R8 program busy length", n, FC);
    send(4'd7, 8'hA3, 0); chk("R2 low byte", rsp_data, 8'hEF);
    send(4'd8, 8'hA3, 0); chk("R2 high byte", rsp_data, 8'hBE);
    send(4'd8, 8'hBF, 0); chk("R2 unloaded high", rsp_data, 8'hFF);
    send(4'd7, 8'hBF, 0); chk("R2 low only", rsp_data, 8'h12);

    // R3 ordering rule
    send(4'd2, 8'h04, 8'h99);
    send(4'd1, 8'h04, 8'h11);
    send(4'd2, 8'h04, 8'h22);
    send(4'd2, 8'h07, 8'h99);
    send(4'd3, 8'h20, 0);
    idle();
    send(4'd8, 8'h24, 0); chk("R3 ordered word", rsp_data, 8'h22);
    send(4'd8, 8'h27, 0); chk("R3 rejected high", rsp_data, 8'hFF);

    // R4 empty commit after commit clears the page
    send(4'd3, 8'hA0, 0);
    idle();
    send(4'd7, 8'hA3, 0); chk("R4 cleared buffer", rsp_data, 8'hFF);

    // R6 single writes, then R5 partial page
    for (int i = 0; i < 4; i++) begin send(4'd6, 8'(12 + i), 8'(8'hA0 + i)); idle(); end
    send(4'd4, 8'h01, 8'h55);
    send(4'd4, 8'h03, 8'h77);
    send(4'd5, 8'h0C, 0);
    n = 1;
    while (busy) begin @(negedge clk); if (busy) n++; end
    chk("R8 data busy length", n, EC);
    send(4'd9, 8'h0C, 0); chk("R5 kept byte0", rsp_data, 8'hA0);
    send(4'd9, 8'h0D, 0); chk("R5 loaded byte1", rsp_data, 8'h55);
    send(4'd9, 8'h0E, 0); chk("R6 single byte", rsp_data, 8'hA2);
    send(4'd9, 8'h0F, 0); chk("R5 loaded byte3", rsp_data, 8'h77);
    send(4'd6, 8'h0D, 8'h01);
    idle();
    send(4'd5, 8'h0C, 0);
    idle();
    send(4'd9, 8'h0D, 0); chk("R5 mask cleared", rsp_data, 8'h01);

    // R9 writes while busy, R11 poll
    send(4'd3, 8'h40, 0);
    send(4'd6, 8'h14, 8'h3C);
    send(4'd11, 8'h00, 0);
    send(4'd10, 8'h00, 0);
    idle();
    send(4'd10, 8'h00, 0); chk("R11 idle poll", rsp_data, 8'h00);
    send(4'd9, 8'h14, 0); chk("R9 ignored write", rsp_data, 8'hFF);
    send(4'd7, 8'hA3, 0); chk("R9 erase ignored", rsp_data, 8'hFF);
    send(4'd9, 8'h0F, 0); chk("R9 data kept", rsp_data, 8'h77);

    // R10 back-pressure
    rsp_ready = 1'b0;
    send(4'd9, 8'h0F, 0);
    @(negedge clk);
    chk("R10 held valid", rsp_valid, 1);
    chk("R10 held data", rsp_data, 8'h77);
    chk("R10 cmd_ready low", cmd_ready, 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 released", rsp_valid, 0);
    send(4'd13, 8'h0F, 8'h00);
    send(4'd9, 8'h0F, 0); chk("R10 undefined opcode", rsp_data, 8'h77);

    // R7 erase
    send(4'd11, 8'h00, 0);
    idle();
    send(4'd9, 8'h0F, 0); chk("R7 data erased", rsp_data, 8'hFF);
    send(4'd8, 8'h24, 0); chk("R7 program erased", rsp_data, 8'hFF);

    // Random mix against the model
    for (int k = 0; k < 600; k++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 12));
      if (op == 4'd11 && $urandom_range(0, 7) != 0) op = 4'd9;
      send(op, 8'($urandom), 8'($urandom));
      if ($urandom_range(0, 9) == 0) idle();
    end
    idle();
    for (int i = 0; i < 64; i++) send(4'd9, 8'(i), 0);
    for (int i = 0; i < 64; i++) send(4'd8, 8'(i * 4 + 1), 0);
    summary();
  end
endmodule